// File: doc/BRIEF.md
# Three-Stage Decimating Filter Chain

This block turns a stream of full-rate modulator samples into filtered 24-bit words at a reduced rate. Samples arrive one per cycle in which `in_en` is high. They pass through three decimating FIR stages in series. The first stage decimates by four with a fixed coefficient set. The second stage decimates by eight, sixteen or thirty-two with a fixed coefficient set. The third stage always halves the rate and takes its coefficients from a small writable bank.

The third stage can be switched out. Stage-two results then go straight to the output, and the block reports the output as only partly filtered. Every stage keeps the most recent samples of its window. At the end of each decimation window it forms the full dot product of those samples with its coefficients. It then rounds the sum, saturates it and passes it on.

After a reset or any reconfiguration the block holds a data-valid flag low. The flag stays low until enough output words have been produced to flush twice the span of the active impulse response plus one word of computation. Any change to the rate select or the bypass control restarts the chain from empty histories. Any accepted coefficient write does the same.

Top module: `decim_chain`

## Requirements
- R1: Every stage forms y = sat(((sum over k of c[k]·x[n-k]) + 2^14) >>> 15), where x[n] is the sample that completes the window and c[k] are 16-bit signed taps. Stage 1 emits one word per 4 accepted inputs, with 8 taps c[k] = 1638·{1,2,3,4,4,3,2,1}[k]. Histories start at zero after reset or restart.
- R2: `dec_sel` picks the stage-2 ratio: 0 selects 8, 1 selects 16, and 2 or 3 select 32. Stage 2 has 16 taps c[k] = 455·{1..8,8..1}[k].
- R3: Stage 3 has 16 taps and emits one word per 2 stage-2 words. Its taps reset to the stage-2 set.
- R4: With `s3_bypass` = 1 the stage-2 words are the output words and `out_full` reads 0. With `s3_bypass` = 0 the stage-3 words are the output words and `out_full` reads 1. `out_full` follows the control one cycle later.
- R5: One `out_stb` pulse arrives per 4·R2·(2 if stage 3 is active, else 1) accepted inputs. It is high in the cycle after the 3rd rising edge following the edge that captured the window-completing input, or after the 2nd such edge in bypass.
- R6: A coefficient write with `cw_we` = 1 stores `cw_data` into stage-3 tap `cw_addr`, but only when `load_en` = 1. With `load_en` = 0 it changes neither the output nor the data-valid flag.
- R7: A change of `dec_sel` or `s3_bypass`, or an accepted write, clears every history and counter and drops results still in flight. `out_valid` is low from the next cycle.
- R8: `out_valid` rises together with the N-th `out_stb` after a restart and stays high until the next restart. N = 2·ceil(span/D)+1, where span = 8 + 4·15 (+ 4·R2·15 with stage 3 active) and D is the overall ratio. N is 19, 19 and 17 for R2 = 8, 16 and 32 with stage 3 active, and 7, 5 and 3 in bypass.
- R9: `out_stb` is a single-cycle pulse, and `out_word` holds its value between pulses.
- R10: Results are saturated to the range -8388608 to 8388607.
- R11: After reset, `out_stb` = 0, `out_valid` = 0, `out_full` = 1 and `out_word` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_en | input | 1 | Input sample enable |
| in_smp | input | 24 | Signed input sample |
| dec_sel | input | 2 | Stage-2 ratio select |
| s3_bypass | input | 1 | Route stage 2 straight to the output |
| load_en | input | 1 | Permits coefficient writes |
| cw_we | input | 1 | Coefficient write strobe |
| cw_addr | input | 4 | Stage-3 tap index |
| cw_data | input | 16 | Signed coefficient value |
| out_word | output | 24 | Filtered result |
| out_stb | output | 1 | One-cycle result strobe |
| out_valid | output | 1 | Settled-data flag |
| out_full | output | 1 | 1 when all three stages are in use |

## Verification
Each output word is due exactly three edges after the capture edge of the input that completes its window, or two edges in bypass. The bench's reference model stamps every predicted word with that due cycle. The bench compares on the falling edge, where any strobe early, late or missing is a mismatch. The data-valid flag is compared at each strobe against the count of words since the last restart. The flag and the filtered-state flag are also read two cycles after every reconfiguration, once the one registered control copy has settled.

// File: rtl/decim_pkg.sv
package decim_pkg;
   localparam int COEF_W = 16;
   localparam int FRAC   = 15;
   localparam int S1_DEC = 4;
   localparam int S3_DEC = 2;

   // symmetric triangular window weight for tap k
   function automatic int tri_weight(input int k, input int taps);
      return (k < taps / 2) ? k + 1 : taps - k;
   endfunction

   // tap value scaled so the window sums to just under unity gain
   function automatic logic [COEF_W-1:0] tri_coef(input int k, input int taps);
      int half;
      int wsum;
      half = taps / 2;
      wsum = half * (half + 1);
      return COEF_W'(((1 << FRAC) / wsum) * tri_weight(k, taps));
   endfunction

   // output words to wait before data counts as settled
   function automatic int settle_len(input int t1, input int t2, input int t3,
                                     input int r2, input bit byp);
      int span;
      int dec;
      span = t1 + S1_DEC * (t2 - 1);
      dec  = S1_DEC * r2;
      if (!byp) begin
         span = span + S1_DEC * r2 * (t3 - 1);
         dec  = dec * S3_DEC;
      end
      return 2 * ((span + dec - 1) / dec) + 1;
   endfunction
endpackage

// File: rtl/decim_fir_stage.sv
module decim_fir_stage
   import decim_pkg::*;
#(
   parameter int TAPS  = 8,
   parameter int DW    = 24,
   parameter int CW    = 16,
   parameter int RW    = 3,
   parameter int ACC_W = DW + CW + $clog2(TAPS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 in_vld,
   input  logic signed [DW-1:0] in_dat,
   input  logic [RW-1:0]        ratio,
   input  logic [TAPS*CW-1:0]   coefs,
   output logic                 out_vld,
   output logic signed [DW-1:0] out_dat
);
   localparam int PW = CW + DW;
   localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) << (FRAC - 1);
   localparam logic signed [ACC_W-1:0] MAXV = {{(ACC_W-DW+1){1'b0}}, {(DW-1){1'b1}}};
   localparam logic signed [ACC_W-1:0] MINV = {{(ACC_W-DW+1){1'b1}}, {(DW-1){1'b0}}};

   if (TAPS < 2) begin : g_bad_taps
      $error("decim_fir_stage: TAPS must be at least 2");
   end
   if (ACC_W < PW + $clog2(TAPS)) begin : g_bad_acc
      $error("decim_fir_stage: accumulator too narrow");
   end

   logic signed [DW-1:0]    hist [TAPS-1];
   logic signed [DW-1:0]    win  [TAPS];
   logic signed [PW-1:0]    prod [TAPS];
   logic [RW-1:0]           cnt;
   logic signed [ACC_W-1:0] acc;
   logic signed [ACC_W-1:0] rnd;
   logic signed [ACC_W-1:0] shf;
   logic signed [DW-1:0]    sat;

   assign win[0] = in_dat;
   for (genvar k = 1; k < TAPS; k++) begin : g_win
      assign win[k] = hist[k-1];
   end

   for (genvar k = 0; k < TAPS; k++) begin : g_mul
      assign prod[k] = $signed(coefs[k*CW +: CW]) * win[k];
   end

   always_comb begin
      acc = '0;
      for (int k = 0; k < TAPS; k++) begin
         acc = acc + {{(ACC_W-PW){prod[k][PW-1]}}, prod[k]};
      end
      rnd = acc + HALF;
      shf = rnd >>> FRAC;
      if (shf > MAXV)      sat = MAXV[DW-1:0];
      else if (shf < MINV) sat = MINV[DW-1:0];
      else                 sat = shf[DW-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         out_vld <= 1'b0;
         out_dat <= '0;
         for (int k = 0; k < TAPS - 1; k++) hist[k] <= '0;
      end else if (clr) begin
         cnt     <= '0;
         out_vld <= 1'b0;
         for (int k = 0; k < TAPS - 1; k++) hist[k] <= '0;
      end else begin
         out_vld <= 1'b0;
         if (in_vld) begin
            hist[0] <= in_dat;
            for (int k = 1; k < TAPS - 1; k++) hist[k] <= hist[k-1];
            if (cnt == ratio - RW'(1)) begin
               cnt     <= '0;
               out_vld <= 1'b1;
               out_dat <= sat;
            end else begin
               cnt <= cnt + RW'(1);
            end
         end
      end
   end

   // R2: the window counter never reaches the active ratio
   assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n || clr)
      cnt < ratio);
   // R1: a result appears only on the edge that took in a sample
   assert_out_after_in_R1: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> ($past(in_vld) && !$past(clr)));
endmodule

// File: rtl/decim_coef_bank.sv
module decim_coef_bank
   import decim_pkg::*;
#(
   parameter int TAPS = 16,
   parameter int CW   = 16,
   parameter int AW   = $clog2(TAPS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ld_en,
   input  logic               we,
   input  logic [AW-1:0]      addr,
   input  logic [CW-1:0]      wdata,
   output logic [TAPS*CW-1:0] coefs,
   output logic               wr_ok
);
   if (CW != COEF_W) begin : g_bad_cw
      $error("decim_coef_bank: CW must equal the package coefficient width");
   end

   logic [CW-1:0] mem [TAPS];

   assign wr_ok = we && ld_en && (int'(addr) < TAPS);

   for (genvar k = 0; k < TAPS; k++) begin : g_flat
      assign coefs[k*CW +: CW] = mem[k];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < TAPS; k++) mem[k] <= tri_coef(k, TAPS);
      end else if (wr_ok) begin
         mem[addr] <= wdata;
      end
   end

   // R6: without the load enable the taps cannot move
   assert_wr_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_en |=> $stable(coefs));
endmodule

// File: rtl/decim_chain.sv
module decim_chain
   import decim_pkg::*;
#(
   parameter int DW = 24,
   parameter int CW = 16,
   parameter int T1 = 8,
   parameter int T2 = 16,
   parameter int T3 = 16,
   parameter int AW = $clog2(T3)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_en,
   input  logic [DW-1:0] in_smp,
   input  logic [1:0]    dec_sel,
   input  logic          s3_bypass,
   input  logic          load_en,
   input  logic          cw_we,
   input  logic [AW-1:0] cw_addr,
   input  logic [CW-1:0] cw_data,
   output logic [DW-1:0] out_word,
   output logic          out_stb,
   output logic          out_valid,
   output logic          out_full
);
   localparam int R1W  = $clog2(S1_DEC) + 1;
   localparam int R2W  = 6;
   localparam int R3W  = $clog2(S3_DEC) + 1;
   localparam int VCW  = 8;
   localparam int N_A8  = settle_len(T1, T2, T3, 8,  1'b0);
   localparam int N_A16 = settle_len(T1, T2, T3, 16, 1'b0);
   localparam int N_A32 = settle_len(T1, T2, T3, 32, 1'b0);
   localparam int N_B8  = settle_len(T1, T2, T3, 8,  1'b1);
   localparam int N_B16 = settle_len(T1, T2, T3, 16, 1'b1);
   localparam int N_B32 = settle_len(T1, T2, T3, 32, 1'b1);

   if (CW != COEF_W) begin : g_bad_cw
      $error("decim_chain: CW must equal the package coefficient width");
   end
   if ((T1 % 2) != 0 || (T2 % 2) != 0) begin : g_bad_taps
      $error("decim_chain: fixed windows need an even tap count");
   end
   if (N_A8 >= 2**VCW || N_A16 >= 2**VCW || N_A32 >= 2**VCW) begin : g_bad_vcw
      $error("decim_chain: settle counter too narrow");
   end

   logic [T1*CW-1:0] c1_flat;
   logic [T2*CW-1:0] c2_flat;
   logic [T3*CW-1:0] c3_flat;
   for (genvar k = 0; k < T1; k++) begin : g_c1
      assign c1_flat[k*CW +: CW] = tri_coef(k, T1);
   end
   for (genvar k = 0; k < T2; k++) begin : g_c2
      assign c2_flat[k*CW +: CW] = tri_coef(k, T2);
   end

   logic [1:0]     sel_q;
   logic           byp_q;
   logic           wr_ok;
   logic           clr;
   logic [R2W-1:0] r2;
   logic           s1_vld, s2_vld, s3_vld, s3_in;
   logic [DW-1:0]  s1_dat, s2_dat, s3_dat;
   logic           fin_vld;
   logic [VCW-1:0] vcnt;
   int             need_n;

   assign clr = (dec_sel != sel_q) || (s3_bypass != byp_q) || wr_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= 2'd0;
         byp_q <= 1'b0;
      end else begin
         sel_q <= dec_sel;
         byp_q <= s3_bypass;
      end
   end

   always_comb begin
      case (sel_q)
         2'd0:    r2 = R2W'(8);
         2'd1:    r2 = R2W'(16);
         default: r2 = R2W'(32);
      endcase
      case ({byp_q, sel_q})
         3'b000:  need_n = N_A8;
         3'b001:  need_n = N_A16;
         3'b100:  need_n = N_B8;
         3'b101:  need_n = N_B16;
         3'b110, 3'b111: need_n = N_B32;
         default: need_n = N_A32;
      endcase
   end

   decim_coef_bank #(.TAPS(T3), .CW(CW), .AW(AW)) u_bank (
      .clk(clk), .rst_n(rst_n), .ld_en(load_en), .we(cw_we), .addr(cw_addr),
      .wdata(cw_data), .coefs(c3_flat), .wr_ok(wr_ok)
   );

   decim_fir_stage #(.TAPS(T1), .DW(DW), .CW(CW), .RW(R1W)) u_s1 (
      .clk(clk), .rst_n(rst_n), .clr(clr), .in_vld(in_en), .in_dat(in_smp),
      .ratio(R1W'(S1_DEC)), .coefs(c1_flat), .out_vld(s1_vld), .out_dat(s1_dat)
   );

   decim_fir_stage #(.TAPS(T2), .DW(DW), .CW(CW), .RW(R2W)) u_s2 (
      .clk(clk), .rst_n(rst_n), .clr(clr), .in_vld(s1_vld), .in_dat(s1_dat),
      .ratio(r2), .coefs(c2_flat), .out_vld(s2_vld), .out_dat(s2_dat)
   );

   assign s3_in = s2_vld && !byp_q;

   decim_fir_stage #(.TAPS(T3), .DW(DW), .CW(CW), .RW(R3W)) u_s3 (
      .clk(clk), .rst_n(rst_n), .clr(clr), .in_vld(s3_in), .in_dat(s2_dat),
      .ratio(R3W'(S3_DEC)), .coefs(c3_flat), .out_vld(s3_vld), .out_dat(s3_dat)
   );

   assign fin_vld = byp_q ? s2_vld : s3_vld;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_stb   <= 1'b0;
         out_word  <= '0;
         out_valid <= 1'b0;
         vcnt      <= '0;
      end else if (clr) begin
         out_stb   <= 1'b0;
         out_valid <= 1'b0;
         vcnt      <= '0;
      end else begin
         out_stb <= fin_vld;
         if (fin_vld) begin
            out_word <= byp_q ? s2_dat : s3_dat;
            if (vcnt != '1) vcnt <= vcnt + VCW'(1);
            if (int'(vcnt) + 1 >= need_n) out_valid <= 1'b1;
         end
      end
   end

   assign out_full = !byp_q;

   // R9: a result strobe never lasts two cycles
   assert_stb_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_stb |=> !out_stb);
   // R7: a restart always drops the settled flag
   assert_restart_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !out_valid);
   // R8: once settled, the flag holds until a restart
   assert_valid_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !clr) |=> out_valid);
   // R4: the third stage stays idle while bypassed
   assert_bypass_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      byp_q |-> !s3_vld);
endmodule

// File: tb/test_decim_chain.sv
module test_decim_chain;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_en = 1'b0;
   logic [23:0] in_smp = '0;
   logic [1:0]  dec_sel = 2'd0;
   logic        s3_bypass = 1'b0;
   logic        load_en = 1'b0;
   logic        cw_we = 1'b0;
   logic [3:0]  cw_addr = '0;
   logic [15:0] cw_data = '0;
   logic [23:0] out_word;
   logic        out_stb, out_valid, out_full;

   int cyc = 0;
   int nchk = 0;
   int nerr = 0;
   string tag = "R11";

   // reference model state
   int c1 [8];
   int c2 [16];
   int c3 [16];
   int h1 [8];
   int h2 [16];
   int h3 [16];
   int n1, n2, n3, r2m, nout, last_word;
   bit bym;
   int q_due [$];
   int q_val [$];
   int q_dv  [$];

   decim_chain i_decim_chain (
      .clk(clk), .rst_n(rst_n), .in_en(in_en), .in_smp(in_smp), .dec_sel(dec_sel),
      .s3_bypass(s3_bypass), .load_en(load_en), .cw_we(cw_we), .cw_addr(cw_addr),
      .cw_data(cw_data), .out_word(out_word), .out_stb(out_stb),
      .out_valid(out_valid), .out_full(out_full)
   );

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic int rsat(input longint acc);
      longint r;
      r = (acc + 64'sd16384) >>> 15;
      if (r > 64'sd8388607)  return 8388607;
      if (r < -64'sd8388608) return -8388608;
      return int'(r);
   endfunction

   // R8 settle counts, written from the requirement table
   function automatic int need_of(input int r, input bit b);
      if (b) return (r == 8) ? 7 : (r == 16) ? 5 : 3;
      return (r == 32) ? 17 : 19;
   endfunction

   function automatic int ratio_of(input logic [1:0] s);
      return (s == 2'd0) ? 8 : (s == 2'd1) ? 16 : 32;
   endfunction

   task automatic chk(input bit ok, input string t, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual %0d expected %0d (cycle %0d)", t, act, exp, cyc);
      end
   endtask

   task automatic model_clear();
      foreach (h1[k]) h1[k] = 0;
      foreach (h2[k]) h2[k] = 0;
      foreach (h3[k]) h3[k] = 0;
      n1 = 0; n2 = 0; n3 = 0; nout = 0;
   endtask

   task automatic model_in(input int x, input int cap);
      longint acc;
      int y;
      for (int k = 7; k > 0; k--) h1[k] = h1[k-1];
      h1[0] = x;
      n1++;
      if (n1 < 4) return;
      n1 = 0;
      acc = 0;
      for (int k = 0; k < 8; k++) acc += longint'(c1[k]) * longint'(h1[k]);
      y = rsat(acc);
      for (int k = 15; k > 0; k--) h2[k] = h2[k-1];
      h2[0] = y;
      n2++;
      if (n2 < r2m) return;
      n2 = 0;
      acc = 0;
      for (int k = 0; k < 16; k++) acc += longint'(c2[k]) * longint'(h2[k]);
      y = rsat(acc);
      if (!bym) begin
         for (int k = 15; k > 0; k--) h3[k] = h3[k-1];
         h3[0] = y;
         n3++;
         if (n3 < 2) return;
         n3 = 0;
         acc = 0;
         for (int k = 0; k < 16; k++) acc += longint'(c3[k]) * longint'(h3[k]);
         y = rsat(acc);
      end
      nout++;
      q_due.push_back(cap + (bym ? 2 : 3));
      q_val.push_back(y);
      q_dv.push_back((nout >= need_of(r2m, bym)) ? 1 : 0);
   endtask

   task automatic check_out();
      int d, v, dv, w;
      w = int'({{8{out_word[23]}}, out_word});
      if (out_stb) begin
         if (q_due.size() == 0) begin
            chk(1'b0, "R5 unexpected strobe", 1, 0);
         end else begin
            d = q_due.pop_front();
            v = q_val.pop_front();
            dv = q_dv.pop_front();
            chk(d == cyc, "R5 strobe timing", cyc, d);
            chk(w == v, tag, w, v);
            chk(int'(out_valid) == dv, "R8 settled flag", int'(out_valid), dv);
            last_word = w;
         end
      end else if (q_due.size() > 0 && q_due[0] <= cyc) begin
         chk(1'b0, "R5 missing strobe", cyc, q_due[0]);
         void'(q_due.pop_front());
         void'(q_val.pop_front());
         void'(q_dv.pop_front());
      end
   endtask

   task automatic tick(input bit en, input int x);
      @(negedge clk);
      check_out();
      in_en = en;
      in_smp = x[23:0];
      if (en) model_in(x, cyc + 1);
   endtask

   task automatic drain();
      repeat (6) tick(1'b0, 0);
      chk(q_due.size() == 0, "R5 outputs drained", q_due.size(), 0);
   endtask

   task automatic set_cfg(input logic [1:0] s, input bit b);
      drain();
      @(negedge clk);
      check_out();
      dec_sel = s;
      s3_bypass = b;
      r2m = ratio_of(s);
      bym = b;
      model_clear();
      tick(1'b0, 0);
      tick(1'b0, 0);
      chk(out_valid == 1'b0, "R7 flag low after restart", int'(out_valid), 0);
      chk(out_full == !b, "R4 filtered-state flag", int'(out_full), int'(!b));
   endtask

   task automatic write_coef(input int a, input int v, input bit ld);
      if (ld) drain();
      @(negedge clk);
      check_out();
      in_en = 1'b0;
      load_en = ld;
      cw_we = 1'b1;
      cw_addr = a[3:0];
      cw_data = v[15:0];
      if (ld) begin
         c3[a] = v;
         model_clear();
      end
      @(negedge clk);
      check_out();
      cw_we = 1'b0;
      load_en = 1'b0;
   endtask

   task automatic run_outs(input int n, input bit rnd, input int x);
      int target;
      int v;
      target = nout + n;
      while (nout < target) begin
         v = rnd ? int'({{8{1'b0}}, 24'($urandom)}) : x;
         if (rnd && v[23]) v = v | 32'hFF00_0000;
         tick(rnd ? (($urandom % 4) != 0) : 1'b1, v);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      for (int k = 0; k < 8; k++)  c1[k] = 1638 * ((k < 4) ? k + 1 : 8 - k);
      for (int k = 0; k < 16; k++) c2[k] = 455 * ((k < 8) ? k + 1 : 16 - k);
      for (int k = 0; k < 16; k++) c3[k] = c2[k];
      r2m = 8; bym = 1'b0; last_word = 0;
      model_clear();
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(out_stb == 1'b0, "R11 strobe at reset", int'(out_stb), 0);
      chk(out_valid == 1'b0, "R11 flag at reset", int'(out_valid), 0);
      chk(out_full == 1'b1, "R11 full flag at reset", int'(out_full), 1);
      chk(out_word == '0, "R11 word at reset", int'(out_word), 0);
      rst_n = 1'b1;

      tag = "R1 R3 full chain, ratio 8";
      run_outs(22, 1'b1, 0);
      set_cfg(2'd0, 1'b1);
      tag = "R4 bypass, ratio 8";
      run_outs(10, 1'b1, 0);
      set_cfg(2'd1, 1'b0);
      tag = "R2 full chain, ratio 16";
      run_outs(21, 1'b1, 0);
      set_cfg(2'd1, 1'b1);
      tag = "R2 bypass, ratio 16";
      run_outs(7, 1'b1, 0);
      set_cfg(2'd2, 1'b0);
      tag = "R2 full chain, ratio 32";
      run_outs(19, 1'b1, 0);
      set_cfg(2'd3, 1'b1);
      tag = "R2 code 3 acts as ratio 32";
      run_outs(5, 1'b1, 0);

      // R6 a gated write must neither restart nor alter results
      set_cfg(2'd0, 1'b0);
      tag = "R6 before gated write";
      run_outs(20, 1'b1, 0);
      write_coef(3, 0, 1'b0);
      tag = "R6 after gated write";
      run_outs(3, 1'b1, 0);
      chk(out_valid == 1'b1, "R6 flag kept after gated write", int'(out_valid), 1);

      // R3 R6 programmed taps
      for (int k = 0; k < 16; k++) write_coef(k, k * 1500 - 9000, 1'b1);
      tag = "R3 R6 programmed taps";
      run_outs(20, 1'b1, 0);

      // R10 saturation with large gain taps
      for (int k = 0; k < 16; k++) write_coef(k, 32767, 1'b1);
      tag = "R10 positive full scale";
      run_outs(6, 1'b0, 8388607);
      chk(last_word == 8388607, "R10 positive clamp", last_word, 8388607);
      tag = "R10 negative full scale";
      run_outs(6, 1'b0, -8388608);
      chk(last_word == -8388608, "R10 negative clamp", last_word, -8388608);
      drain();

      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end
endmodule